// File: doc/BRIEF.md
# Wake-on-LAN Magic Packet Detector

The detector sits beside a receive MAC and watches the byte stream of each incoming frame. It looks for a wake frame. Such a frame carries a run of six 0xFF bytes somewhere after the frame header. That run is followed by sixteen back-to-back copies of the station's 48-bit MAC address. When the frame closes with a good CRC, the block raises a sticky wake flag that system firmware later clears.

Whether detection is armed depends on the power state. At full power, a software enable bit arms the search. In the low-power state the search is armed automatically, whatever the enable bit says. The byte stream is qualified by a valid strobe and a start-of-frame marker on the first byte. End of frame is a separate strobe, carrying no data, that comes with the CRC verdict.

Top module: `wol_magic_detect`

## Requirements
- R1: After reset `wake_o` is low.
- R2: A frame whose payload holds six consecutive 0xFF bytes, followed at once by sixteen consecutive copies of `station_addr_i`, and which ends with `rx_eof_i` and `rx_crc_ok_i` both high, drives `wake_o` high in the cycle after the end-of-frame strobe.
- R3: The first `HDR_BYTES` bytes of a frame (default 14, counting the start-of-frame byte as byte 0) take no part in the search, so a sync run or address copies placed there do not count.
- R4: A non-0xFF byte inside the sync run, or a mismatching byte inside the address repeats, restarts the search. If the breaking byte is 0xFF, it counts as the first byte of a new sync run. Extra 0xFF bytes right after a complete sync run, before the first address byte, keep the sync.
- R5: An end-of-frame strobe with `rx_crc_ok_i` low never sets `wake_o`.
- R6: A start-of-frame that arrives before the previous frame's end-of-frame discards any partial match of that previous frame.
- R7: With `pwr_low_i` = 0 (full power), detection happens only while `mp_en_i` = 1. With `mp_en_i` = 0, a valid wake frame leaves `wake_o` low.
- R8: With `pwr_low_i` = 1 (low power), detection is armed regardless of `mp_en_i`.
- R9: `wake_o` stays high until `wake_clr_i` is pulsed and goes low the cycle after the pulse. If the clear coincides with an end-of-frame that completes a detection, `wake_o` stays high.
- R10: Bytes that follow the sixteenth address copy (CRC bytes or any other bytes) do not undo a completed match.
- R11: Address bytes are compared most significant byte first: `station_addr_i[47:40]` is the first byte of each copy. A byte-reversed address does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_sof_i | input | 1 | Marks the first byte of a frame (with rx_valid_i) |
| rx_eof_i | input | 1 | End-of-frame strobe, no data in that cycle |
| rx_crc_ok_i | input | 1 | CRC verdict, sampled with rx_eof_i |
| station_addr_i | input | 48 | Station MAC address, first transmitted byte in [47:40] |
| mp_en_i | input | 1 | Detection enable used at full power |
| pwr_low_i | input | 1 | 0 = full-power state, 1 = low-power state |
| wake_clr_i | input | 1 | Clears the wake flag |
| wake_o | output | 1 | Sticky wake status |

## Verification
Two events can fall in the same cycle: the clearing of the flag and a new detection setting it. The bench provokes this by pulsing `wake_clr_i` in the very cycle of a good end-of-frame that closes a wake frame. It expects the flag to remain high. A following clear-only pulse must bring the flag low. Random frames mix sync fragments, address bytes and corruptions, and each result is compared with a bench model of the search.

// File: rtl/wol_pkg.sv
package wol_pkg;
  localparam int unsigned SYNC_LEN_DEF = 6;
  localparam int unsigned REPS_DEF     = 16;
  localparam int unsigned HDR_DEF      = 14;
  localparam int unsigned ADDR_BYTES   = 6;
  localparam logic [7:0]  SYNC_BYTE    = 8'hFF;
endpackage

// File: rtl/wol_hdr_gate.sv
module wol_hdr_gate #(
  parameter int unsigned HDR_BYTES = wol_pkg::HDR_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic sof_i,
  input  logic eof_i,
  output logic payload_o
);
  localparam int unsigned PW = $clog2(HDR_BYTES + 1);
  localparam logic [PW-1:0] HDR_L = PW'(HDR_BYTES);

  logic [PW-1:0] pos_q;

  assign payload_o = !sof_i && (pos_q >= HDR_L);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         pos_q <= '0;
    else if (eof_i)                      pos_q <= '0;
    else if (valid_i && sof_i)           pos_q <= PW'(1);
    else if (valid_i && pos_q < HDR_L)   pos_q <= pos_q + PW'(1);
  end
endmodule

// File: rtl/wol_seq_match.sv
module wol_seq_match #(
  parameter int unsigned SYNC_LEN = wol_pkg::SYNC_LEN_DEF,
  parameter int unsigned REPS     = wol_pkg::REPS_DEF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        byte_vld_i,
  input  logic [7:0]  byte_i,
  input  logic [8*wol_pkg::ADDR_BYTES-1:0] addr_i,
  output logic        found_o
);
  import wol_pkg::*;
  localparam int unsigned FW = $clog2(SYNC_LEN + 1);
  localparam int unsigned RW = $clog2(REPS);
  localparam int unsigned BW = $clog2(ADDR_BYTES);
  localparam logic [FW-1:0] SYNC_L = FW'(SYNC_LEN);
  localparam logic [RW-1:0] LAST_R = RW'(REPS - 1);
  localparam logic [BW-1:0] LAST_B = BW'(ADDR_BYTES - 1);

  logic [7:0] addr_b [ADDR_BYTES];
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_abyte
    // first transmitted byte sits in the top lane
    assign addr_b[g] = addr_i[8*(ADDR_BYTES-1-g) +: 8];
  end

  logic [FW-1:0] ff_q, ff_d;
  logic [RW-1:0] rep_q, rep_d;
  logic [BW-1:0] bidx_q, bidx_d;
  logic          found_q, found_d;
  logic          is_ff, synced, hit;

  assign is_ff  = (byte_i == SYNC_BYTE);
  assign synced = (ff_q == SYNC_L);
  assign hit    = (byte_i == addr_b[bidx_q]);

  always_comb begin
    ff_d = ff_q; rep_d = rep_q; bidx_d = bidx_q; found_d = found_q;
    if (clr_i) begin
      ff_d = '0; rep_d = '0; bidx_d = '0; found_d = 1'b0;
    end else if (byte_vld_i && !found_q) begin
      if (!synced) begin
        ff_d = is_ff ? ff_q + FW'(1) : '0;
      end else if (hit) begin
        if (bidx_q == LAST_B) begin
          bidx_d = '0;
          if (rep_q == LAST_R) found_d = 1'b1;
          else                 rep_d = rep_q + RW'(1);
        end else begin
          bidx_d = bidx_q + BW'(1);
        end
      end else if (is_ff && rep_q == '0 && bidx_q == '0) begin
        ff_d = ff_q; // sync run longer than required
      end else begin
        rep_d = '0; bidx_d = '0;
        ff_d  = is_ff ? FW'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff_q <= '0; rep_q <= '0; bidx_q <= '0; found_q <= 1'b0;
    end else begin
      ff_q <= ff_d; rep_q <= rep_d; bidx_q <= bidx_d; found_q <= found_d;
    end
  end

  assign found_o = found_q;
endmodule

// File: rtl/wol_wake_flag.sv
module wol_wake_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic wake_o
);
  logic wake_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    wake_q <= 1'b0;
    else if (set_i) wake_q <= 1'b1; // set wins over clear
    else if (clr_i) wake_q <= 1'b0;
  end
  assign wake_o = wake_q;
endmodule

// File: rtl/wol_magic_detect.sv
module wol_magic_detect #(
  parameter int unsigned HDR_BYTES = wol_pkg::HDR_DEF,
  parameter int unsigned SYNC_LEN  = wol_pkg::SYNC_LEN_DEF,
  parameter int unsigned REPS      = wol_pkg::REPS_DEF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_sof_i,
  input  logic        rx_eof_i,
  input  logic        rx_crc_ok_i,
  input  logic [47:0] station_addr_i,
  input  logic        mp_en_i,
  input  logic        pwr_low_i,
  input  logic        wake_clr_i,
  output logic        wake_o
);
  logic armed, payload, found, seq_clr, wake_set;

  assign armed = pwr_low_i | mp_en_i;

  wol_hdr_gate #(.HDR_BYTES(HDR_BYTES)) u_hdr (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(rx_valid_i),
    .sof_i(rx_sof_i), .eof_i(rx_eof_i), .payload_o(payload)
  );

  assign seq_clr = (rx_valid_i & rx_sof_i) | rx_eof_i | !armed;

  wol_seq_match #(.SYNC_LEN(SYNC_LEN), .REPS(REPS)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(seq_clr),
    .byte_vld_i(rx_valid_i & payload), .byte_i(rx_data_i),
    .addr_i(station_addr_i), .found_o(found)
  );

  assign wake_set = rx_eof_i & rx_crc_ok_i & found & armed;

  wol_wake_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(wake_set),
    .clr_i(wake_clr_i), .wake_o(wake_o)
  );
endmodule

// File: rtl/wol_magic_detect_chk.sv
module wol_magic_detect_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_eof_i,
  input logic rx_crc_ok_i,
  input logic mp_en_i,
  input logic pwr_low_i,
  input logic wake_clr_i,
  input logic wake_o
);
  // R2
  rise_on_good_eof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> $past(rx_eof_i && rx_crc_ok_i));
  // R5
  bad_crc_no_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_eof_i && !rx_crc_ok_i && !wake_o && !wake_clr_i) |=> !wake_o);
  // R7
  armed_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> $past(mp_en_i || pwr_low_i));
  // R9
  sticky_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && !wake_clr_i) |=> wake_o);
  // R9
  clear_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_clr_i && !rx_eof_i) |=> !wake_o);
endmodule

bind wol_magic_detect wol_magic_detect_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_eof_i(rx_eof_i), .rx_crc_ok_i(rx_crc_ok_i),
  .mp_en_i(mp_en_i), .pwr_low_i(pwr_low_i), .wake_clr_i(wake_clr_i), .wake_o(wake_o)
);

// File: tb/wol_magic_detect_test.sv
module wol_magic_detect_test;
  localparam int HDR = 14;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic rx_valid_i = 0, rx_sof_i = 0, rx_eof_i = 0, rx_crc_ok_i = 0;
  logic [7:0] rx_data_i = 8'h00;
  logic [47:0] station_addr_i = 48'h0A1B2C3D4E5F;
  logic mp_en_i = 0, pwr_low_i = 0, wake_clr_i = 0;
  logic wake_o;
  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] fr[$];

  always #10 clk_i = ~clk_i;

  wol_magic_detect uut (.*);

  task automatic chk(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: wake_o=%0b expected %0b", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ab(input logic [47:0] a, input int i);
    return a[8*(5-i) +: 8];
  endfunction

  // search model from the requirements
  function automatic bit model(input logic [7:0] q[$], input logic [47:0] a);
    int ff = 0, rep = 0, bi = 0;
    for (int p = HDR; p < q.size(); p++) begin
      if (ff < 6) ff = (q[p] == 8'hFF) ? ff + 1 : 0;
      else if (q[p] == ab(a, bi)) begin
        if (bi == 5) begin bi = 0; rep++; if (rep == 16) return 1'b1; end
        else bi++;
      end else if (q[p] == 8'hFF && rep == 0 && bi == 0) begin
      end else begin
        rep = 0; bi = 0; ff = (q[p] == 8'hFF) ? 1 : 0;
      end
    end
    return 1'b0;
  endfunction

  task automatic hdr_fill();
    fr.delete();
    for (int i = 0; i < HDR; i++) fr.push_back(8'(i + 8'h30));
  endtask
  task automatic add_sync(input int n);
    for (int i = 0; i < n; i++) fr.push_back(8'hFF);
  endtask
  task automatic add_reps(input int n, input logic [47:0] a);
    for (int r = 0; r < n; r++) for (int i = 0; i < 6; i++) fr.push_back(ab(a, i));
  endtask
  task automatic add_crc();
    for (int i = 0; i < 4; i++) fr.push_back(8'($urandom));
  endtask

  task automatic send_bytes();
    foreach (fr[i]) begin
      @(negedge clk_i);
      rx_valid_i = 1; rx_data_i = fr[i]; rx_sof_i = (i == 0);
    end
    @(negedge clk_i);
    rx_valid_i = 0; rx_sof_i = 0;
  endtask

  task automatic clear_flag();
    @(negedge clk_i); wake_clr_i = 1;
    @(negedge clk_i); wake_clr_i = 0;
  endtask

  task automatic run(input bit crc, input bit clr_eof, input bit exp, input string req);
    send_bytes();
    rx_eof_i = 1; rx_crc_ok_i = crc; wake_clr_i = clr_eof;
    @(negedge clk_i);
    rx_eof_i = 0; rx_crc_ok_i = 0; wake_clr_i = 0;
    chk(wake_o, exp, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: wake_o=%0b expected 0", wake_o);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    chk(wake_o, 1'b0, "R1 reset");
    rst_ni = 1;
    mp_en_i = 1; pwr_low_i = 0;

    // R2 / R11 basic
    hdr_fill(); add_sync(6); add_reps(16, station_addr_i); add_crc();
    run(1, 0, 1, "R2 magic frame");
    clear_flag(); chk(wake_o, 1'b0, "R9 clear");

    // R3 sync in header
    fr.delete();
    for (int i = 0; i < 8; i++) fr.push_back(8'h11);
    add_sync(6); add_reps(16, station_addr_i); add_crc();
    run(1, 0, 0, "R3 sync in header");

    // R4 broken sync then good; broken repeat resynced by FF
    hdr_fill(); add_sync(5); fr.push_back(8'h00); add_sync(6);
    add_reps(16, station_addr_i); add_crc();
    run(1, 0, 1, "R4 broken sync restart"); clear_flag();
    hdr_fill(); add_sync(6); add_reps(3, station_addr_i); add_sync(6);
    add_reps(16, station_addr_i); add_crc();
    run(1, 0, 1, "R4 FF restarts sync"); clear_flag();
    hdr_fill(); add_sync(9); add_reps(16, station_addr_i); add_crc();
    run(1, 0, 1, "R4 long sync run"); clear_flag();
    hdr_fill(); add_sync(6); add_reps(7, station_addr_i); fr.push_back(8'h00);
    add_reps(9, station_addr_i); add_crc();
    run(1, 0, 0, "R4 broken repeat");

    // R5 bad CRC
    hdr_fill(); add_sync(6); add_reps(16, station_addr_i); add_crc();
    run(0, 0, 0, "R5 bad crc");

    // R6 abort then continuation
    hdr_fill(); add_sync(6); add_reps(8, station_addr_i); send_bytes();
    hdr_fill(); add_reps(8, station_addr_i); add_crc();
    run(1, 0, 0, "R6 aborted frame");

    // R7 / R8 power states
    mp_en_i = 0;
    hdr_fill(); add_sync(6); add_reps(16, station_addr_i); add_crc();
    run(1, 0, 0, "R7 disabled full power");
    pwr_low_i = 1;
    run(1, 0, 1, "R8 low power auto arm");
    // R9 clear in detection cycle
    clear_flag();
    run(1, 1, 1, "R9 clear with set");
    clear_flag(); chk(wake_o, 1'b0, "R9 clear after");
    pwr_low_i = 0; mp_en_i = 1;

    // R10 trailing bytes
    hdr_fill(); add_sync(6); add_reps(16, station_addr_i);
    for (int i = 0; i < 10; i++) fr.push_back(8'h5A);
    add_crc();
    run(1, 0, 1, "R10 trailing bytes"); clear_flag();

    // R11 reversed order
    hdr_fill(); add_sync(6); add_reps(16, 48'h5F4E3D2C1B0A); add_crc();
    run(1, 0, 0, "R11 reversed address");

    // random frames
    for (int n = 0; n < 200; n++) begin
      bit crc, exp;
      int kind;
      hdr_fill();
      for (int i = 0; i < int'($urandom_range(0, 8)); i++)
        fr.push_back(($urandom_range(0, 2) == 0) ? 8'hFF : 8'($urandom));
      kind = $urandom_range(0, 3);
      if (kind != 3) begin
        add_sync($urandom_range(5, 8));
        add_reps((kind == 2) ? $urandom_range(10, 16) : 16, station_addr_i);
        if (kind == 1) fr[$urandom_range(HDR, fr.size() - 1)] = 8'($urandom);
      end else begin
        for (int i = 0; i < 40; i++)
          fr.push_back(($urandom_range(0, 1) == 0) ? 8'hFF : ab(station_addr_i, $urandom_range(0, 5)));
      end
      add_crc();
      crc = ($urandom_range(0, 4) != 0);
      mp_en_i = 1'($urandom); pwr_low_i = 1'($urandom);
      exp = model(fr, station_addr_i) && crc && (mp_en_i || pwr_low_i);
      run(crc, 0, exp, "R2 R4 R5 R7 R8 random");
      clear_flag();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule